// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a bus or DMA master and an audio serializer. It holds two sample queues: a playback queue, filled by the bus and drained by the serializer, and a capture queue, filled by the serializer and drained by the bus. Each queue asks for service when it crosses a programmable level. The playback request rises while the queue is nearly empty. The capture request rises while the queue holds more than its level. Both requests leave room for a 16-word burst, so one service request can move a whole burst.

A small write-only register port sets the two 4-bit request levels and the underrun policy. The same port gives self-clearing flush and soft-reset strobes, a loopback switch and four interrupt enables. When the serializer pulls from an empty playback queue, the block records an underrun. It then feeds the serializer either a repeat of the last word or zero. When the serializer pushes into a full capture queue, the word is dropped and an overrun is recorded. A build parameter selects a variant in which the playback flush strobe clears both queues.

Top module: `aud_fifo_pair`

## Requirements
- R1: After reset both levels are 0, the playback level is 8, the capture level is 7, both sticky flags and `irq` are 0, `tx_req` is 1, `rx_req` is 0 and `ser_tx_word` is 0.
- R2: Each queue holds DEPTH (32) words and returns them in write order. A `tx_push` into a full playback queue and an `rx_pop` from an empty capture queue are ignored: the level and `rx_data` are unchanged. Each level moves by at most one per cycle, except on a flush.
- R3: `tx_req` is 1 exactly when `tx_level` <= the playback level. `rx_req` is 1 exactly when `rx_level` > the capture level. Both levels are set by a write to address 0: bits [3:0] hold the playback level and bits [7:4] hold the capture level.
- R4: A write to address 1 with bit 0 set flushes the playback queue, and with bit 1 set flushes the capture queue. The flush takes effect at the clock edge after the write. It empties that queue and clears its sticky flag. The flush bits do not hold, so the queue fills normally afterwards.
- R5: With SHARED_FLUSH=1, address-1 bit 0 empties both queues and clears both flags. Address-1 bit 1 has no effect.
- R6: A `ser_tx_pull` while `tx_level` is 0 sets `tx_underrun`, which stays set until a flush or reset. The pulled word is the last word sent when address-0 bit 8 is 1, and zero when it is 0.
- R7: A serializer push while `rx_level` is DEPTH sets `rx_overrun`. The word is dropped.
- R8: `irq` is the OR of four sources, each gated by its enable in address 1: bit 4 for underrun, bit 5 for overrun, bit 6 for `tx_req` and bit 7 for `rx_req`. With all four enables clear, `irq` stays 0.
- R9: When address-1 bit 2 is set, each word sent to the serializer is written into the capture queue one cycle after the pull. Pushes from the serializer are ignored while this bit is set.
- R10: A write to address 0 with bit 15 set returns the whole block, registers included, to its R1 state at the following clock edge.
- R11: While `tx_req` is 1, the playback queue has at least 16 free words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 configuration, 1 control |
| cfg_wdata | input | 16 | Register write data |
| tx_push | input | 1 | Bus writes a playback word |
| tx_data | input | DW | Playback word from the bus |
| rx_pop | input | 1 | Bus reads a capture word |
| rx_data | output | DW | Capture word, valid the cycle after `rx_pop` |
| ser_tx_pull | input | 1 | Serializer takes a playback word |
| ser_tx_word | output | DW | Playback word, valid the cycle after `ser_tx_pull` |
| ser_rx_push | input | 1 | Serializer delivers a capture word |
| ser_rx_word | input | DW | Capture word from the serializer |
| tx_level | output | log2(DEPTH)+1 | Playback queue occupancy |
| rx_level | output | log2(DEPTH)+1 | Capture queue occupancy |
| tx_req | output | 1 | Playback service request |
| rx_req | output | 1 | Capture service request |
| tx_underrun | output | 1 | Sticky playback underrun flag |
| rx_overrun | output | 1 | Sticky capture overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
The level-step properties assume that a queue moves by at most one word per port per cycle. The stimulus raises each strobe for single cycles only and never flushes and soft-resets in the same write. The burst-room property relies on a DEPTH of at least 31, and the bench keeps the default. The underrun and overrun properties assume that a flush or soft reset does not coincide with the offending access. The bench schedules flush writes only after all pulls and pushes have stopped.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  localparam int REG_W      = 16;
  localparam int BURST      = 16;
  localparam int TX_THR_RST = 8;
  localparam int RX_THR_RST = 7;

  // configuration register (address 0)
  localparam int CF_TXTHR_LO = 0;
  localparam int CF_RXTHR_LO = 4;
  localparam int CF_HOLD     = 8;
  localparam int CF_SRST     = 15;

  // control register (address 1)
  localparam int CT_TXFL = 0;
  localparam int CT_RXFL = 1;
  localparam int CT_LOOP = 2;
  localparam int CT_IETU = 4;
  localparam int CT_IERO = 5;
  localparam int CT_IETR = 6;
  localparam int CT_IERR = 7;

  typedef struct packed {
    logic loopback;
    logic ie_tur;
    logic ie_ror;
    logic ie_txr;
    logic ie_rxr;
  } ctrl_t;
endpackage

// File: rtl/aud_fifo_buf.sv
module aud_fifo_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wdata,
  input  logic                     rd_en,
  output logic [DW-1:0]            rdata,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_en && (level != LW'(DEPTH)) && !clr;
  assign rd_ok = rd_en && (level != '0) && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/aud_fifo_regs.sv
module aud_fifo_regs
  import aud_fifo_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic              hold_last,
  output ctrl_t             ctrl,
  output logic              tx_flush_p,
  output logic              rx_flush_p,
  output logic              srst_p
);
  logic unused_bits;
  assign unused_bits = ^{wdata[14:9], wdata[3]};

  always_ff @(posedge clk) begin
    if (rst || srst_p) begin
      tx_thr     <= THR_W'(TX_THR_RST);
      rx_thr     <= THR_W'(RX_THR_RST);
      hold_last  <= 1'b0;
      ctrl       <= '0;
      tx_flush_p <= 1'b0;
      rx_flush_p <= 1'b0;
      srst_p     <= 1'b0;
    end else begin
      tx_flush_p <= 1'b0;
      rx_flush_p <= 1'b0;
      srst_p     <= 1'b0;
      if (we && !addr) begin
        tx_thr    <= wdata[CF_TXTHR_LO +: THR_W];
        rx_thr    <= wdata[CF_RXTHR_LO +: THR_W];
        hold_last <= wdata[CF_HOLD];
        srst_p    <= wdata[CF_SRST];
      end
      if (we && addr) begin
        tx_flush_p    <= wdata[CT_TXFL];
        rx_flush_p    <= wdata[CT_RXFL];
        ctrl.loopback <= wdata[CT_LOOP];
        ctrl.ie_tur   <= wdata[CT_IETU];
        ctrl.ie_ror   <= wdata[CT_IERO];
        ctrl.ie_txr   <= wdata[CT_IETR];
        ctrl.ie_rxr   <= wdata[CT_IERR];
      end
    end
  end
endmodule

// File: rtl/aud_fifo_pair.sv
module aud_fifo_pair
  import aud_fifo_pkg::*;
#(
  parameter int DW           = 16,
  parameter int DEPTH        = 32,
  parameter int THR_W        = 4,
  parameter bit SHARED_FLUSH = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic                    cfg_addr,
  input  logic [15:0]             cfg_wdata,
  input  logic                    tx_push,
  input  logic [DW-1:0]           tx_data,
  input  logic                    rx_pop,
  output logic [DW-1:0]           rx_data,
  input  logic                    ser_tx_pull,
  output logic [DW-1:0]           ser_tx_word,
  input  logic                    ser_rx_push,
  input  logic [DW-1:0]           ser_rx_word,
  output logic [$clog2(DEPTH):0]  tx_level,
  output logic [$clog2(DEPTH):0]  rx_level,
  output logic                    tx_req,
  output logic                    rx_req,
  output logic                    tx_underrun,
  output logic                    rx_overrun,
  output logic                    irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [THR_W-1:0] tx_thr, rx_thr;
  logic             hold_last;
  ctrl_t            ctrl;
  logic             tx_flush_p, rx_flush_p, srst_p;
  logic             blk_rst, tx_clr, rx_clr;
  logic [DW-1:0]    tx_rdata, rx_wdata;
  logic             rx_wr, und_last, lb_v, ie_any;

  assign blk_rst = rst | srst_p;

  aud_fifo_regs #(.THR_W(THR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .hold_last(hold_last), .ctrl(ctrl),
    .tx_flush_p(tx_flush_p), .rx_flush_p(rx_flush_p), .srst_p(srst_p)
  );

  assign tx_clr = tx_flush_p;
  generate
    if (SHARED_FLUSH) begin : g_shared_flush
      assign rx_clr = tx_flush_p;
    end else begin : g_split_flush
      assign rx_clr = rx_flush_p;
    end
  endgenerate

  aud_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(blk_rst), .clr(tx_clr), .wr_en(tx_push), .wdata(tx_data),
    .rd_en(ser_tx_pull), .rdata(tx_rdata), .level(tx_level)
  );

  // loopback tap: the word handed out on a pull enters capture one cycle later
  assign rx_wr    = lb_v | (!ctrl.loopback & ser_rx_push);
  assign rx_wdata = lb_v ? ser_tx_word : ser_rx_word;

  aud_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(blk_rst), .clr(rx_clr), .wr_en(rx_wr), .wdata(rx_wdata),
    .rd_en(rx_pop), .rdata(rx_data), .level(rx_level)
  );

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
      und_last    <= 1'b0;
      lb_v        <= 1'b0;
    end else begin
      lb_v <= ser_tx_pull & ctrl.loopback;
      if (ser_tx_pull) und_last <= (tx_level == '0) | tx_clr;
      if (tx_clr)                                  tx_underrun <= 1'b0;
      else if (ser_tx_pull && tx_level == '0)      tx_underrun <= 1'b1;
      if (rx_clr)                                  rx_overrun <= 1'b0;
      else if (rx_wr && rx_level == LW'(DEPTH))    rx_overrun <= 1'b1;
    end
  end

  // a starved pull either repeats the held read register or sends zero
  assign ser_tx_word = (und_last && !hold_last) ? '0 : tx_rdata;

  assign tx_req = tx_level <= LW'(tx_thr);
  assign rx_req = rx_level >  LW'(rx_thr);
  assign ie_any = ctrl.ie_tur | ctrl.ie_ror | ctrl.ie_txr | ctrl.ie_rxr;
  assign irq    = (ctrl.ie_tur & tx_underrun) | (ctrl.ie_ror & rx_overrun) |
                  (ctrl.ie_txr & tx_req)      | (ctrl.ie_rxr & rx_req);
endmodule

// File: rtl/aud_fifo_pair_chk.sv
module aud_fifo_pair_chk
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_req,
  input logic          irq,
  input logic          tx_underrun,
  input logic          rx_overrun,
  input logic          ser_tx_pull,
  input logic          rx_pop,
  input logic          rx_wr,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic          srst_p,
  input logic          ie_any
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

  // R2
  tx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_clr && !srst_p) |=> (int'(tx_level) <= int'($past(tx_level)) + 1) &&
                             (int'(tx_level) + 1 >= int'($past(tx_level))));

  // R4
  tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> (tx_level == '0) && !tx_underrun);

  // R4
  rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (rx_level == '0) && !rx_overrun);

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_tx_pull && tx_level == '0 && !tx_clr && !srst_p) |=> tx_underrun);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_wr && !rx_pop && int'(rx_level) == DEPTH && !rx_clr && !srst_p)
      |=> rx_overrun && int'(rx_level) == DEPTH);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !ie_any |-> !irq);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst_p |=> (tx_level == '0) && (rx_level == '0) && !tx_underrun && !rx_overrun);

  // R11
  burst_room_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (DEPTH - int'(tx_level)) >= BURST);
endmodule

bind aud_fifo_pair aud_fifo_pair_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
  .tx_req(tx_req), .irq(irq), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
  .ser_tx_pull(ser_tx_pull), .rx_pop(rx_pop), .rx_wr(rx_wr),
  .tx_clr(tx_clr), .rx_clr(rx_clr), .srst_p(srst_p), .ie_any(ie_any)
);

// File: tb/test_aud_fifo_pair.sv
module test_aud_fifo_pair;
  localparam int DW = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic cfg_we = 0, cfg_addr = 0;
  logic [15:0] cfg_wdata = '0;
  logic tx_push = 0, rx_pop = 0, ser_tx_pull = 0, ser_rx_push = 0;
  logic [DW-1:0] tx_data = '0, ser_rx_word = '0;
  logic [DW-1:0] rx_data, ser_tx_word;
  logic [5:0] tx_level, rx_level;
  logic tx_req, rx_req, tx_underrun, rx_overrun, irq;

  aud_fifo_pair i_aud_fifo_pair (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
    .ser_tx_pull(ser_tx_pull), .ser_tx_word(ser_tx_word),
    .ser_rx_push(ser_rx_push), .ser_rx_word(ser_rx_word),
    .tx_level(tx_level), .rx_level(rx_level), .tx_req(tx_req), .rx_req(rx_req),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .irq(irq)
  );

  // shared-flush variant
  logic s_we = 0, s_addr = 0, s_txp = 0, s_rxp = 0;
  logic [15:0] s_wd = '0;
  logic [DW-1:0] s_rx_data, s_tx_word;
  logic [5:0] s_txl, s_rxl;
  logic s_txr, s_rxr, s_tu, s_ro, s_irq;

  aud_fifo_pair #(.SHARED_FLUSH(1'b1)) i_aud_fifo_pair_shared (
    .clk(clk), .rst(rst), .cfg_we(s_we), .cfg_addr(s_addr), .cfg_wdata(s_wd),
    .tx_push(s_txp), .tx_data(16'h0042), .rx_pop(1'b0), .rx_data(s_rx_data),
    .ser_tx_pull(1'b0), .ser_tx_word(s_tx_word),
    .ser_rx_push(s_rxp), .ser_rx_word(16'h0077),
    .tx_level(s_txl), .rx_level(s_rxl), .tx_req(s_txr), .rx_req(s_rxr),
    .tx_underrun(s_tu), .rx_overrun(s_ro), .irq(s_irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic push_tx(input logic [DW-1:0] d);
    tx_push = 1; tx_data = d; tick(); tx_push = 0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d);
    ser_rx_push = 1; ser_rx_word = d; tick(); ser_rx_push = 0;
  endtask

  task automatic pull_tx();
    ser_tx_pull = 1; tick(); ser_tx_pull = 0;
  endtask

  task automatic pop_rx();
    rx_pop = 1; tick(); rx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {tx_underrun, rx_overrun}, 0);
    chk("R1 ser_tx_word", ser_tx_word, 0);

    // R3 / R11 playback threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr_reg(0, 16'(t) | 16'h0070);
      for (int l = 0; l <= 20; l++) begin
        chk("R3 tx_level", tx_level, l);
        chk("R3 tx_req", tx_req, (l <= t) ? 1 : 0);
        push_tx(16'(l));
      end
      wr_reg(1, 16'h0001);
      tick();
      chk("R4 tx flush", tx_level, 0);
    end
    wr_reg(0, 16'h0078);

    // R2 order and full queue
    for (int i = 0; i < 34; i++) push_tx(16'h1000 + 16'(i));
    chk("R2 full level", tx_level, 32);
    chk("R3 tx_req full", tx_req, 0);
    for (int i = 0; i < 32; i++) begin
      pull_tx();
      chk("R2 order", ser_tx_word, 16'h1000 + i);
      chk("R2 drain level", tx_level, 31 - i);
    end
    // R6 zero fill
    pull_tx();
    chk("R6 zero word", ser_tx_word, 0);
    chk("R6 underrun flag", tx_underrun, 1);
    chk("R6 level stays", tx_level, 0);
    // R6 repeat last
    wr_reg(0, 16'h0178);
    push_tx(16'hBEEF);
    pull_tx();
    chk("R6 normal word", ser_tx_word, 16'hBEEF);
    pull_tx();
    chk("R6 repeat word", ser_tx_word, 16'hBEEF);
    chk("R6 sticky", tx_underrun, 1);
    wr_reg(1, 16'h0001);
    tick();
    chk("R4 flush clears underrun", tx_underrun, 0);

    // R3 capture threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr_reg(0, 16'(t << 4) | 16'h0008);
      for (int l = 0; l <= 20; l++) begin
        chk("R3 rx_level", rx_level, l);
        chk("R3 rx_req", rx_req, (l > t) ? 1 : 0);
        push_rx(16'(l));
      end
      wr_reg(1, 16'h0002);
      tick();
      chk("R4 rx flush", rx_level, 0);
    end
    wr_reg(0, 16'h0078);

    // R7 overrun and R2 capture order
    for (int i = 0; i < 32; i++) push_rx(16'h2000 + 16'(i));
    chk("R7 no overrun yet", rx_overrun, 0);
    push_rx(16'hDEAD);
    chk("R7 overrun flag", rx_overrun, 1);
    chk("R7 level held", rx_level, 32);
    for (int i = 0; i < 32; i++) begin
      pop_rx();
      chk("R2 rx order", rx_data, 16'h2000 + i);
    end
    chk("R7 dropped word absent", rx_level, 0);
    pop_rx();
    chk("R2 empty pop level", rx_level, 0);
    chk("R2 empty pop data", rx_data, 16'h201F);

    // R4 independent flushes
    for (int i = 0; i < 3; i++) push_tx(16'(i));
    for (int i = 0; i < 2; i++) push_rx(16'(i));
    wr_reg(1, 16'h0002);
    chk("R4 not yet", rx_level, 2);
    tick();
    chk("R4 rx emptied", rx_level, 0);
    chk("R4 overrun cleared", rx_overrun, 0);
    chk("R4 tx untouched", tx_level, 3);
    push_rx(16'h0001);
    chk("R4 self-clearing", rx_level, 1);
    wr_reg(1, 16'h0001);
    tick();
    chk("R4 tx emptied", tx_level, 0);
    chk("R4 rx untouched", rx_level, 1);

    // R8 interrupt masking
    wr_reg(1, 16'h0000);
    chk("R8 all masked", irq, 0);
    wr_reg(1, 16'h0040);
    chk("R8 tx req irq", irq, 1);
    for (int i = 0; i < 9; i++) push_tx(16'(i));
    chk("R8 tx req gone", irq, 0);
    wr_reg(1, 16'h0001);
    tick();
    wr_reg(1, 16'h0010);
    chk("R8 underrun irq idle", irq, 0);
    pull_tx();
    chk("R8 underrun irq", irq, 1);
    wr_reg(1, 16'h0000);
    chk("R8 underrun masked", irq, 0);
    chk("R8 flag kept", tx_underrun, 1);
    wr_reg(1, 16'h0080);
    chk("R8 rx req idle", irq, 0);
    for (int i = 0; i < 7; i++) push_rx(16'(i));
    chk("R8 rx req irq", irq, 1);
    wr_reg(1, 16'h0020);
    chk("R8 overrun idle", irq, 0);
    for (int i = 0; i < 25; i++) push_rx(16'(i));
    chk("R8 overrun irq", irq, 1);
    wr_reg(1, 16'h0003);
    tick();
    chk("R4 both flags cleared", {tx_underrun, rx_overrun}, 0);

    // R9 loopback
    wr_reg(1, 16'h0004);
    for (int i = 0; i < 5; i++) push_tx(16'h3000 + 16'(i));
    ser_tx_pull = 1; ser_rx_push = 1; ser_rx_word = 16'h5555;
    repeat (5) tick();
    ser_tx_pull = 0;
    tick();
    ser_rx_push = 0;
    chk("R9 looped count", rx_level, 5);
    chk("R9 tx drained", tx_level, 0);
    for (int i = 0; i < 5; i++) begin
      pop_rx();
      chk("R9 looped data", rx_data, 16'h3000 + i);
    end

    // R10 soft reset
    wr_reg(0, 16'h0002);
    for (int i = 0; i < 5; i++) push_tx(16'(i));
    wr_reg(1, 16'h0040);
    chk("R10 pre tx_req", tx_req, 0);
    wr_reg(0, 16'h8000);
    tick();
    chk("R10 level", tx_level, 0);
    chk("R10 tx_req", tx_req, 1);
    chk("R10 irq enables cleared", irq, 0);
    for (int i = 0; i < 8; i++) push_tx(16'(i));
    chk("R10 threshold 8 at 8", tx_req, 1);
    push_tx(16'h0009);
    chk("R10 threshold 8 at 9", tx_req, 0);

    // R5 shared flush variant
    for (int i = 0; i < 4; i++) begin s_txp = 1; tick(); s_txp = 0; end
    for (int i = 0; i < 3; i++) begin s_rxp = 1; tick(); s_rxp = 0; end
    s_we = 1; s_addr = 1; s_wd = 16'h0002; tick(); s_we = 0;
    tick();
    chk("R5 rx bit no effect tx", s_txl, 4);
    chk("R5 rx bit no effect rx", s_rxl, 3);
    s_we = 1; s_addr = 1; s_wd = 16'h0001; tick(); s_we = 0;
    tick();
    chk("R5 shared tx", s_txl, 0);
    chk("R5 shared rx", s_rxl, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule